// File: doc/BRIEF.md
# Pipelined Bus Memory Controller

This controller connects a pipelined 32-bit processor bus to a word-wide synchronous memory. The processor announces each bus cycle one clock early on two request pins, an active-low memory request and a sequential flag. At every clock edge that completes a bus cycle, the controller latches that pair into a cycle-type register. The register's value then governs the following cycle, which is one of four kinds: nonsequential, sequential, internal or coprocessor transfer.

Only nonsequential and sequential cycles reach the memory. A nonsequential cycle is stretched by a parameterised number of wait states, reported through an active-low wait output. A sequential cycle completes in one clock. Writes go out with one enable per byte lane, derived from the size code, the low address bits and the selected endianness. Reads come back right-aligned and zero-extended. In internal and coprocessor cycles the read bus is released and nothing is written. A small behavioural memory array inside the block lets it run without any external memory.

Top module: `mc_pipe_memctl`

## Requirements
- R1: At a completing edge the pair {memReqN, seqReq} selects the type of the next cycle, reported on cycType: 00 nonsequential (code 0), 01 sequential (code 1), 10 internal (code 2), 11 coprocessor transfer (code 3).
- R2: While waitN is low the request pins are not sampled, and cycType holds its value.
- R3: A nonsequential cycle holds waitN low for exactly N_WAIT clocks (default 1) and completes in the clock after the last of them.
- R4: A sequential cycle completes in its first clock, with waitN high.
- R5: Internal and coprocessor cycles keep waitN high and assert no lane write enable.
- R6: In internal and coprocessor cycles, and in write cycles, rdOe is low and rdData is zero.
- R7: With bigEndian low, a write in its completing clock asserts laneWe as follows. accSize 00 (byte) asserts lane addr[1:0] only. accSize 01 (halfword) asserts lanes 1:0 when addr[1] is 0 and lanes 3:2 when addr[1] is 1. accSize 10 or 11 (word) asserts all four lanes.
- R8: With bigEndian high, byte address offset k uses lane 3-k. A byte write asserts lane 3-addr[1:0]; a halfword write asserts lanes 3:2 when addr[1] is 0 and lanes 1:0 when addr[1] is 1.
- R9: A read returns, in its completing clock, the addressed byte or halfword zero-extended in rdData[7:0] or rdData[15:0], with rdOe high. Bytes are ordered by the selected endianness, and the byte at the lowest address is the most significant one in big-endian mode.
- R10: Alignment is forced: addr[0] is ignored for halfword accesses and addr[1:0] for word accesses.
- R11: A byte or halfword write leaves the other bytes of the word unchanged.
- R12: After reset the cycle type is internal, waitN is high, no lane enable is asserted and rdOe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| memReqN | input | 1 | Active-low memory request for the next cycle |
| seqReq | input | 1 | Sequential flag for the next cycle |
| isWrite | input | 1 | Current cycle is a write |
| accSize | input | 2 | Access size: 00 byte, 01 halfword, 1x word |
| addr | input | 32 | Byte address of the current cycle |
| wrData | input | 32 | Write data, right-aligned for subword sizes |
| bigEndian | input | 1 | Select big-endian lane mapping |
| waitN | output | 1 | Active-low wait to the processor |
| cycType | output | 2 | Type of the current cycle |
| laneWe | output | 4 | Per-lane write enables to the memory |
| rdData | output | 32 | Steered read data |
| rdOe | output | 1 | Read bus driven |

## Verification
The bench runs one stream of cycles in which the cycle types follow each other in several orders: nonsequential then sequential, internal and coprocessor cycles placed between accesses, and reads that follow writes. This separates the timing of each cycle type from the type decode. The same word, halfword and byte accesses are run in both endian modes, which tells lane mapping apart from read steering. During every wait clock the request pins carry a coprocessor code, so any sampling of the pins while the cycle is stretched appears on cycType. Misaligned offsets and subword writes followed by full-word reads show that alignment is forced and that neighbouring bytes are preserved.

// File: rtl/mc_pkg.sv
package mc_pkg;
  typedef enum logic [1:0] {
    CYC_N = 2'd0,
    CYC_S = 2'd1,
    CYC_I = 2'd2,
    CYC_C = 2'd3
  } cyc_e;

  typedef struct packed {
    logic wrCommit;
    logic rdDrive;
  } strobe_t;
endpackage

// File: rtl/mc_ctrl.sv
module mc_ctrl
  import mc_pkg::*;
#(
  parameter int N_WAIT = 1
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    memReqN,
  input  logic    seqReq,
  input  logic    isWrite,
  output logic    waitN,
  output cyc_e    cycType,
  output strobe_t strb
);
  localparam int CW = $clog2(N_WAIT + 1);

  cyc_e          curType;
  logic [CW-1:0] waitCnt;
  logic          stall;
  logic          access;

  assign stall   = (curType == CYC_N) && (waitCnt < CW'(N_WAIT));
  assign access  = (curType == CYC_N) || (curType == CYC_S);
  assign waitN   = !stall;
  assign cycType = curType;

  always_comb begin
    strb.wrCommit = access && isWrite && !stall;
    strb.rdDrive  = access && !isWrite && !stall;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curType <= CYC_I;
      waitCnt <= '0;
    end else if (stall) begin
      waitCnt <= waitCnt + 1'b1;
    end else begin
      waitCnt <= '0;
      curType <= cyc_e'({memReqN, seqReq});
    end
  end
endmodule

// File: rtl/mc_datapath.sv
module mc_datapath
  import mc_pkg::*;
#(
  parameter int DEPTH = 64
) (
  input  logic        clk,
  input  strobe_t     strb,
  input  logic [31:0] addr,
  input  logic [1:0]  accSize,
  input  logic [31:0] wrData,
  input  logic        bigEndian,
  output logic [3:0]  laneWe,
  output logic [31:0] rdData,
  output logic        rdOe
);
  localparam int IW = $clog2(DEPTH);

  logic [31:0]   mem [DEPTH];
  logic [IW-1:0] wordIdx;
  logic [1:0]    byteLane;
  logic          halfHigh;
  logic [3:0]    sizeMask;
  logic [31:0]   wrLanes;
  logic [31:0]   rdWord;
  logic [31:0]   steered;

  assign wordIdx  = addr[IW+1:2];
  assign byteLane = bigEndian ? ~addr[1:0] : addr[1:0];
  assign halfHigh = bigEndian ? ~addr[1] : addr[1];

  always_comb begin
    case (accSize)
      2'b00: begin
        sizeMask = 4'b0001 << byteLane;
        wrLanes  = {4{wrData[7:0]}};
      end
      2'b01: begin
        sizeMask = halfHigh ? 4'b1100 : 4'b0011;
        wrLanes  = {2{wrData[15:0]}};
      end
      default: begin
        sizeMask = 4'b1111;
        wrLanes  = wrData;
      end
    endcase
  end

  assign laneWe = sizeMask & {4{strb.wrCommit}};

  always_ff @(posedge clk) begin
    for (int g = 0; g < 4; g++) begin
      if (laneWe[g]) mem[wordIdx][8*g +: 8] <= wrLanes[8*g +: 8];
    end
  end

  assign rdWord = mem[wordIdx];

  always_comb begin
    case (accSize)
      2'b00:   steered = {24'd0, rdWord[8*byteLane +: 8]};
      2'b01:   steered = {16'd0, halfHigh ? rdWord[31:16] : rdWord[15:0]};
      default: steered = rdWord;
    endcase
  end

  assign rdOe   = strb.rdDrive;
  assign rdData = strb.rdDrive ? steered : 32'd0;
endmodule

// File: rtl/mc_pipe_memctl.sv
module mc_pipe_memctl
  import mc_pkg::*;
#(
  parameter int N_WAIT = 1,
  parameter int DEPTH  = 64
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        memReqN,
  input  logic        seqReq,
  input  logic        isWrite,
  input  logic [1:0]  accSize,
  input  logic [31:0] addr,
  input  logic [31:0] wrData,
  input  logic        bigEndian,
  output logic        waitN,
  output logic [1:0]  cycType,
  output logic [3:0]  laneWe,
  output logic [31:0] rdData,
  output logic        rdOe
);
  strobe_t strb;
  cyc_e    curType;

  mc_ctrl #(.N_WAIT(N_WAIT)) ctrl_i (
    .clk(clk), .rstN(rstN), .memReqN(memReqN), .seqReq(seqReq),
    .isWrite(isWrite), .waitN(waitN), .cycType(curType), .strb(strb)
  );

  mc_datapath #(.DEPTH(DEPTH)) dp_i (
    .clk(clk), .strb(strb), .addr(addr), .accSize(accSize),
    .wrData(wrData), .bigEndian(bigEndian), .laneWe(laneWe),
    .rdData(rdData), .rdOe(rdOe)
  );

  assign cycType = curType;
endmodule

// File: rtl/mc_memctl_chk.sv
module mc_memctl_chk (
  input logic        clk,
  input logic        rstN,
  input logic        memReqN,
  input logic        seqReq,
  input logic        waitN,
  input logic [1:0]  cycType,
  input logic [3:0]  laneWe,
  input logic [31:0] rdData,
  input logic        rdOe
);
  AST_IDLE_NO_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    cycType[1] |-> (laneWe == 4'b0000 && waitN)); // R5

  AST_BUS_RELEASED: assert property (@(posedge clk) disable iff (!rstN)
    cycType[1] |-> (!rdOe && rdData == 32'd0)); // R6

  AST_SEQ_NO_WAIT: assert property (@(posedge clk) disable iff (!rstN)
    (cycType == 2'd1) |-> waitN); // R4

  AST_NSEQ_STARTS_WAIT: assert property (@(posedge clk) disable iff (!rstN)
    (waitN && !memReqN && !seqReq) |=> !waitN); // R3

  AST_TYPE_HELD: assert property (@(posedge clk) disable iff (!rstN)
    !waitN |=> $stable(cycType)); // R2

  AST_LANE_COUNT: assert property (@(posedge clk) disable iff (!rstN)
    ($countones(laneWe) != 3)); // R7

  AST_NO_WRITE_DURING_WAIT: assert property (@(posedge clk) disable iff (!rstN)
    !waitN |-> (laneWe == 4'b0000 && !rdOe)); // R3
endmodule

bind mc_pipe_memctl mc_memctl_chk chk_i (
  .clk(clk), .rstN(rstN), .memReqN(memReqN), .seqReq(seqReq),
  .waitN(waitN), .cycType(cycType), .laneWe(laneWe),
  .rdData(rdData), .rdOe(rdOe)
);

// File: tb/mc_pipe_memctl_tb.sv
`timescale 1ns/1ps
module mc_pipe_memctl_tb_top;
  localparam int NW = 1;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        memReqN = 1'b1;
  logic        seqReq = 1'b0;
  logic        isWrite = 1'b0;
  logic [1:0]  accSize = 2'b10;
  logic [31:0] addr = '0;
  logic [31:0] wrData = '0;
  logic        bigEndian = 1'b0;
  logic        waitN;
  logic [1:0]  cycType;
  logic [3:0]  laneWe;
  logic [31:0] rdData;
  logic        rdOe;

  always #10 clk = ~clk;

  mc_pipe_memctl #(.N_WAIT(NW), .DEPTH(64)) dut_i (
    .clk(clk), .rstN(rstN), .memReqN(memReqN), .seqReq(seqReq),
    .isWrite(isWrite), .accSize(accSize), .addr(addr), .wrData(wrData),
    .bigEndian(bigEndian), .waitN(waitN), .cycType(cycType),
    .laneWe(laneWe), .rdData(rdData), .rdOe(rdOe)
  );

  typedef struct {
    int          typ;
    logic [31:0] a;
    bit          wr;
    int          sz;
    logic [31:0] d;
    bit          big;
    string       tag;
  } op_t;

  op_t         ops[$];
  logic [7:0]  memModel[int];
  int          expType;
  int          expCnt;
  int          nChecks = 0;
  int          nFails = 0;
  bit          done = 0;
  bit          heldLast = 0;

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic addOp(int typ, logic [31:0] a, bit wr, int sz, logic [31:0] d, bit big, string tag);
    op_t o;
    o.typ = typ; o.a = a; o.wr = wr; o.sz = sz; o.d = d; o.big = big; o.tag = tag;
    ops.push_back(o);
  endtask

  function automatic int baseOf(logic [31:0] a, int sz);
    if (sz == 0) return int'(a);
    if (sz == 1) return int'(a) & ~1;
    return int'(a) & ~3;
  endfunction

  function automatic int lenOf(int sz);
    return (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
  endfunction

  function automatic logic [3:0] expLanes(logic [31:0] a, int sz, bit big);
    logic [3:0] r = '0;
    int b = baseOf(a, sz);
    for (int i = 0; i < lenOf(sz); i++) begin
      int off = (b + i) & 3;
      r[big ? 3 - off : off] = 1'b1;
    end
    return r;
  endfunction

  function automatic logic [31:0] expRead(logic [31:0] a, int sz, bit big);
    logic [31:0] v = '0;
    int b = baseOf(a, sz);
    int n = lenOf(sz);
    for (int i = 0; i < n; i++) begin
      logic [7:0] x = memModel.exists(b + i) ? memModel[b + i] : 8'hxx;
      if (big) v = (v << 8) | {24'd0, x};
      else     v = v | ({24'd0, x} << (8 * i));
    end
    return v;
  endfunction

  task automatic modelWrite(logic [31:0] a, int sz, logic [31:0] d, bit big);
    int b = baseOf(a, sz);
    int n = lenOf(sz);
    for (int i = 0; i < n; i++) begin
      int sh = big ? 8 * (n - 1 - i) : 8 * i;
      memModel[b + i] = 8'(d >> sh);
    end
  endtask

  function automatic bit expWait();
    return !(expType == 0 && expCnt < NW);
  endfunction

  task automatic compareAll(string tag);
    bit access = (expType == 0 || expType == 1);
    bit ew = expWait();
    bit doWr = access && isWrite && ew;
    bit doRd = access && !isWrite && ew;
    string wreq = (expType == 0) ? "R3" : (expType == 1) ? "R4" : "R5";
    int sz = int'(accSize);
    if (sz == 3) sz = 2;
    check(heldLast ? "R2" : "R1", "cycType", {30'd0, cycType}, expType);
    check(wreq, "waitN", {31'd0, waitN}, {31'd0, ew});
    if (!access)  check("R5", "laneWe idle", {28'd0, laneWe}, 32'd0);
    else if (doWr) check(bigEndian ? "R8" : "R7", "laneWe", {28'd0, laneWe},
                        {28'd0, expLanes(addr, sz, bigEndian)});
    else          check("R3", "laneWe none", {28'd0, laneWe}, 32'd0);
    check(doRd ? "R9" : "R6", "rdOe", {31'd0, rdOe}, {31'd0, doRd});
    check(doRd ? tag : "R6", "rdData", rdData, doRd ? expRead(addr, sz, bigEndian) : 32'd0);
  endtask

  task automatic modelStep();
    if (expType == 0 && expCnt < NW) begin
      expCnt++;
    end else begin
      int sz = (int'(accSize) == 3) ? 2 : int'(accSize);
      if ((expType == 0 || expType == 1) && isWrite) modelWrite(addr, sz, wrData, bigEndian);
      expCnt = 0;
      expType = {30'd0, memReqN, seqReq};
    end
  endtask

  task automatic runOp(int k);
    int it = 0;
    bit stallNow;
    int nxt = (k + 1 < ops.size()) ? ops[k+1].typ : 2;
    do begin
      @(negedge clk);
      addr      = ops[k].a;
      isWrite   = ops[k].wr;
      accSize   = 2'(ops[k].sz);
      wrData    = ops[k].d;
      bigEndian = ops[k].big;
      if (it == 0 && expType == 0) {memReqN, seqReq} = 2'b11; // R2 garbage while waiting
      else {memReqN, seqReq} = 2'(nxt);
      #1;
      compareAll(ops[k].tag);
      stallNow = !expWait();
      @(posedge clk);
      modelStep();
      heldLast = stallNow;
      it++;
    end while (stallNow);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      nFails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    // Little-endian stream
    addOp(2, 32'h0, 0, 2, 0, 0, "R1");
    addOp(0, 32'h0, 1, 2, 32'h11223344, 0, "R7");
    addOp(1, 32'h4, 1, 2, 32'h55667788, 0, "R7");
    addOp(0, 32'h1, 1, 0, 32'h000000AA, 0, "R7");
    addOp(1, 32'h6, 1, 1, 32'h0000BEEF, 0, "R7");
    addOp(2, 32'h0, 0, 2, 0, 0, "R5");
    addOp(0, 32'h0, 0, 2, 0, 0, "R11");
    addOp(1, 32'h4, 0, 2, 0, 0, "R11");
    addOp(0, 32'h1, 0, 0, 0, 0, "R9");
    addOp(1, 32'h6, 0, 1, 0, 0, "R9");
    addOp(3, 32'h0, 0, 2, 0, 0, "R6");
    addOp(0, 32'h3, 0, 2, 0, 0, "R10");
    addOp(0, 32'h3, 0, 1, 0, 0, "R10");
    addOp(1, 32'h7, 1, 3, 32'hCAFEF00D, 0, "R10");
    addOp(0, 32'h4, 0, 2, 0, 0, "R10");
    // Big-endian stream
    addOp(0, 32'h8, 1, 2, 32'hA1B2C3D4, 1, "R8");
    addOp(1, 32'h9, 1, 0, 32'h0000005A, 1, "R8");
    addOp(0, 32'hA, 1, 1, 32'h00001357, 1, "R8");
    addOp(3, 32'h0, 0, 2, 0, 1, "R6");
    addOp(0, 32'h8, 0, 2, 0, 1, "R11");
    addOp(1, 32'h8, 0, 0, 0, 1, "R9");
    addOp(1, 32'h9, 0, 1, 0, 1, "R10");
    addOp(1, 32'hB, 0, 0, 0, 1, "R9");
    addOp(2, 32'h0, 0, 2, 0, 1, "R5");
    addOp(3, 32'h0, 0, 2, 0, 1, "R6");

    expType = 2;
    expCnt = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    #1;
    check("R12", "reset cycType", {30'd0, cycType}, 32'd2);
    check("R12", "reset waitN", {31'd0, waitN}, 32'd1);
    check("R12", "reset laneWe", {28'd0, laneWe}, 32'd0);
    check("R12", "reset rdOe", {31'd0, rdOe}, 32'd0);
    memReqN = 1'b1;
    seqReq = 1'b0;
    rstN = 1'b1;
    @(posedge clk);
    expType = 2;
    expCnt = 0;
    for (int k = 0; k < ops.size(); k++) runOp(k);

    // R12: reset in the middle of a nonsequential wait
    @(negedge clk);
    {memReqN, seqReq} = 2'b00;
    isWrite = 1'b1;
    @(posedge clk);
    modelStep();
    @(negedge clk);
    rstN = 1'b0;
    @(posedge clk);
    @(negedge clk);
    #1;
    check("R12", "mid-wait reset cycType", {30'd0, cycType}, 32'd2);
    check("R12", "mid-wait reset waitN", {31'd0, waitN}, 32'd1);
    check("R12", "mid-wait reset laneWe", {28'd0, laneWe}, 32'd0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule